// File: doc/BRIEF.md
# Zero-Suppression Event Packetizer

This block sits after per-channel correction in a strip readout front end. For every bunch crossing it takes the corrected samples of all channels, one per clock in channel order, and keeps only those strictly above a programmable threshold. When the scan of a crossing is complete it sends out one event record. The record is a header word followed by one word per kept hit, and each hit word holds the channel number and its sample value. Hits are never reordered.

A two-bit policy input selects when a header is sent and what its size field means. A one-bit width input selects a 3-bit or a 4-bit hit count, and with it the most hits an event can carry. Hits beyond that maximum are dropped in channel order. Each drop raises a sticky flag and advances a saturating counter. The output is a word stream with valid, ready and last. While an event is being sent, no new samples are accepted.

Top module: `zs_event_packer`

## Requirements
- R1: A sample is a hit only when its value is strictly greater than `threshold`. A value equal to the threshold is not a hit.
- R2: A hit word has `out_hdr`=0 and `out_size_vld`=0. Bits [12:6] hold the channel index and bits [5:0] hold the sample, with zeros above. Hit words follow the header in ascending channel order.
- R3: A header word has `out_hdr`=1. Bits [27:16] hold the bunch number sampled with channel 0, bits [15:9] the sensor number, bits [8:4] the chip number and bits [3:0] the size field, which is 0 whenever it is not sent.
- R4: Policy 1 (`cfg_policy`=1) sends a header every crossing. With n>0 hits, `out_size_vld`=1 and size=n-1. With no hits, the header alone is sent with `out_size_vld`=0.
- R5: Policy 2 (`cfg_policy`=2, or 0) sends a header every crossing with `out_size_vld`=1 and size=n, so an empty crossing gives size 0. It keeps at most 7 hits (narrow) or 15 hits (wide).
- R6: Policy 3 (`cfg_policy`=3) sends nothing for an empty crossing. Otherwise it sends a header with `out_size_vld`=1 and size=n-1.
- R7: Policies 1 and 3 keep at most 8 hits (`cfg_wide`=0) or 16 hits (`cfg_wide`=1). The first hits in channel order are kept and the rest are discarded.
- R8: Every discarded hit adds one to `drop_count`, which saturates. Any discard sets `ovf_flag`, and only reset clears it.
- R9: Each event's final word has `out_last`=1. While `out_valid` is high and `out_ready` is low, the word and its flags hold.
- R10: `in_ready` is low from the cycle after a crossing's last sample until its event is fully sent. Policy, width and bunch number are taken with channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample accepted when high with in_valid |
| in_adc | input | ADC_W | Corrected sample, channels in order |
| bunch_id | input | 12 | Bunch counter |
| sensor_id | input | 7 | Static sensor number |
| chip_id | input | 5 | Static chip number |
| threshold | input | ADC_W | Hit threshold |
| cfg_policy | input | 2 | Header policy |
| cfg_wide | input | 1 | 1: 4-bit size field, 0: 3-bit |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | 28 | Header or hit word |
| out_hdr | output | 1 | Word is a header |
| out_size_vld | output | 1 | Header carries a size field |
| out_last | output | 1 | Final word of event |
| ovf_flag | output | 1 | Sticky truncation flag |
| drop_count | output | DROP_W | Saturating dropped-hit count |

## Verification
A wrong hit count or limit in the buffer shows up in the next header's size field. It also shows up as a missing or extra hit word and as a wrong `drop_count`, all within the same event, about two cycles after the last sample. A corrupt buffer entry or read index shows up as a wrong channel or value in a hit word. A fault in the sender's state shows up as a changed word during a stall, a missing `out_last`, an extra word after the last one, or `in_ready` rising while an event is still being sent. The bench compares every accepted word against a queue model and checks the flags at the end of each crossing.

// File: rtl/zsp_pkg.sv
// Shared field widths, header policy encoding and the hit limit rule.
// Assumes the header layout {bunch, sensor, chip, size} fixed by the consumer.
package zsp_pkg;
    localparam int BUNCH_W   = 12;
    localparam int SENSOR_W  = 7;
    localparam int CHIP_W    = 5;
    localparam int SIZE_W    = 4;
    localparam int ID_W      = BUNCH_W + SENSOR_W + CHIP_W;
    localparam int OUT_W     = ID_W + SIZE_W;
    localparam int MAX_HITS  = 2 ** SIZE_W;
    localparam int HIT_CNT_W = SIZE_W + 1;

    typedef enum logic [1:0] {
        POL_ZERO        = 2'd0,
        POL_SIZE_ON_HIT = 2'd1,
        POL_FULL        = 2'd2,
        POL_HIT_ONLY    = 2'd3
    } policy_e;

    // Largest number of hits an event may carry under a policy and width.
    function automatic logic [HIT_CNT_W-1:0] hit_limit(policy_e p, logic wide);
        logic [HIT_CNT_W-1:0] base;
        base = wide ? HIT_CNT_W'(MAX_HITS) : HIT_CNT_W'(MAX_HITS / 2);
        return (p == POL_FULL) ? base - 1'b1 : base;
    endfunction
endpackage

// File: rtl/zsp_hit_store.sv
// Hit buffer: appends hits of one crossing up to a limit, counts the ones
// that do not fit. Assumes clr and the first write of a crossing coincide.
module zsp_hit_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 13,
    parameter int CNT_W   = 5,
    parameter int DROP_W  = 16,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [CNT_W-1:0]   limit,
    input  logic [ENTRY_W-1:0] wr_entry,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_entry,
    output logic [CNT_W-1:0]   count,
    output logic               ovf,
    output logic [DROP_W-1:0]  drop_cnt
);
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]   base;
    logic               room;

    assign base     = clr ? '0 : count;
    assign room     = base < limit;
    assign rd_entry = mem[rd_idx];

    // Track how many hits the current crossing holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr && room)
            count <= base + 1'b1;
        else if (clr)
            count <= '0;
    end

    // Store an accepted hit at the next free slot.
    always_ff @(posedge clk) begin
        if (wr && room)
            mem[base[IDX_W-1:0]] <= wr_entry;
    end

    // Record hits refused for lack of room.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf      <= 1'b0;
            drop_cnt <= '0;
        end else if (wr && !room) begin
            ovf <= 1'b1;
            if (drop_cnt != {DROP_W{1'b1}})
                drop_cnt <= drop_cnt + 1'b1;
        end
    end

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf) |-> ovf);
endmodule

// File: rtl/zsp_emitter.sv
// Event sender: after a scan, emits the header (if the policy asks for one)
// then the buffered hits. Assumes count and buffer stay stable while busy.
module zsp_emitter
    import zsp_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 13,
    parameter int CNT_W   = 5,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  policy_e            policy,
    input  logic [CNT_W-1:0]   count,
    input  logic [ID_W-1:0]    hdr_id,
    input  logic [ENTRY_W-1:0] rd_entry,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               busy,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data,
    output logic               out_hdr,
    output logic               out_size_vld,
    output logic               out_last
);
    typedef enum logic [1:0] {S_IDLE, S_HDR, S_HITS} state_e;
    state_e           state;
    logic [IDX_W-1:0] idx;
    logic [SIZE_W-1:0] size_f;
    logic             hit_last;

    assign size_f   = (policy == POL_FULL) ? SIZE_W'(count) : (count == '0) ? '0 : SIZE_W'(count - 1'b1);
    assign hit_last = (CNT_W'(idx) + 1'b1) == count;
    assign rd_idx   = idx;
    assign busy     = state != S_IDLE;

    // Drive the output word from the current state.
    always_comb begin
        out_valid    = state != S_IDLE;
        out_hdr      = state == S_HDR;
        out_size_vld = (state == S_HDR) && !(policy == POL_SIZE_ON_HIT && count == '0);
        out_data     = '0;
        out_last     = 1'b0;
        if (state == S_HDR) begin
            out_data = {hdr_id, size_f};
            out_last = count == '0;
        end else if (state == S_HITS) begin
            out_data = {{(OUT_W-ENTRY_W){1'b0}}, rd_entry};
            out_last = hit_last;
        end
    end

    // Step through header and hits as words are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start && !(policy == POL_HIT_ONLY && count == '0)) state <= S_HDR;
                S_HDR: if (out_ready) begin
                    idx   <= '0;
                    state <= (count == '0) ? S_IDLE : S_HITS;
                end
                S_HITS: if (out_ready) begin
                    if (hit_last) state <= S_IDLE;
                    else          idx   <= idx + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_hdr)));
    assert_gap_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/zs_event_packer.sv
// Top: scans NUM_CH samples per crossing in channel order, buffers hits
// above threshold, then sends the event. Assumes sample 0 is the first
// sample taken after reset or after the previous crossing.
module zs_event_packer
    import zsp_pkg::*;
#(
    parameter int NUM_CH  = 128,
    parameter int ADC_W   = 6,
    parameter int DROP_W  = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int ENTRY_W = CH_W + ADC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADC_W-1:0]    in_adc,
    input  logic [BUNCH_W-1:0]  bunch_id,
    input  logic [SENSOR_W-1:0] sensor_id,
    input  logic [CHIP_W-1:0]   chip_id,
    input  logic [ADC_W-1:0]    threshold,
    input  logic [1:0]          cfg_policy,
    input  logic                cfg_wide,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OUT_W-1:0]    out_data,
    output logic                out_hdr,
    output logic                out_size_vld,
    output logic                out_last,
    output logic                ovf_flag,
    output logic [DROP_W-1:0]   drop_count
);
    logic [CH_W-1:0]      chan;
    logic                 accept, first, final_s, done_q, busy;
    policy_e              pol_in, pol_q, pol_cur;
    logic                 wide_q, wide_cur;
    logic [BUNCH_W-1:0]   bunch_q;
    logic [HIT_CNT_W-1:0] limit, count;
    logic [ENTRY_W-1:0]   rd_entry;
    logic [$clog2(MAX_HITS)-1:0] rd_idx;

    assign pol_in   = (cfg_policy == 2'd0) ? POL_FULL : policy_e'(cfg_policy);
    assign in_ready = !busy && !done_q;
    assign accept   = in_valid && in_ready;
    assign first    = accept && (chan == '0);
    assign final_s  = accept && (chan == CH_W'(NUM_CH - 1));
    assign pol_cur  = first ? pol_in : pol_q;
    assign wide_cur = first ? cfg_wide : wide_q;
    assign limit    = hit_limit(pol_cur, wide_cur);

    // Count channel position within the crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan <= '0;
        else if (accept)
            chan <= final_s ? '0 : chan + 1'b1;
    end

    // Capture per-crossing settings with channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q   <= POL_FULL;
            wide_q  <= 1'b0;
            bunch_q <= '0;
        end else if (first) begin
            pol_q   <= pol_in;
            wide_q  <= cfg_wide;
            bunch_q <= bunch_id;
        end
    end

    // Flag the cycle after the last sample so the sender can start.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= final_s;
    end

    zsp_hit_store #(.DEPTH(MAX_HITS), .ENTRY_W(ENTRY_W), .CNT_W(HIT_CNT_W), .DROP_W(DROP_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(first), .wr(accept && (in_adc > threshold)),
        .limit(limit), .wr_entry({chan, in_adc}), .rd_idx(rd_idx), .rd_entry(rd_entry),
        .count(count), .ovf(ovf_flag), .drop_cnt(drop_count)
    );

    zsp_emitter #(.DEPTH(MAX_HITS), .ENTRY_W(ENTRY_W), .CNT_W(HIT_CNT_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .start(done_q), .policy(pol_q), .count(count),
        .hdr_id({bunch_q, sensor_id, chip_id}), .rd_entry(rd_entry), .rd_idx(rd_idx),
        .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_hdr(out_hdr), .out_size_vld(out_size_vld), .out_last(out_last)
    );

    assert_no_input_while_sending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    assert_count_in_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hdr && out_size_vld && pol_q != POL_FULL) |-> (count != '0));
endmodule

// File: tb/test_zs_event_packer.sv
module test_zs_event_packer;
    localparam int NCH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_adc = '0;
    logic [11:0] bunch_id = '0;
    logic [6:0]  sensor_id = 7'h5A;
    logic [4:0]  chip_id = 5'h13;
    logic [5:0]  threshold = 6'd3;
    logic [1:0]  cfg_policy = 2'd1;
    logic        cfg_wide = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [27:0] out_data;
    logic        out_hdr, out_size_vld, out_last, ovf_flag;
    logic [15:0] drop_count;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rmode = 0;
    int vals[NCH];
    logic [30:0] expq[$];
    int exp_drops = 0;
    bit exp_ovf = 1'b0;

    always #5 clk = ~clk;

    zs_event_packer i_zs_event_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_adc(in_adc),
        .bunch_id(bunch_id), .sensor_id(sensor_id), .chip_id(chip_id), .threshold(threshold),
        .cfg_policy(cfg_policy), .cfg_wide(cfg_wide), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_hdr(out_hdr), .out_size_vld(out_size_vld), .out_last(out_last),
        .ovf_flag(ovf_flag), .drop_count(drop_count)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the output stream with the model queue.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
            if (out_valid) begin
                check("R10 in_ready during send", in_ready, 0);
                if (out_ready) begin
                    if (expq.size() == 0) begin
                        check("R6/R9 unexpected word", {out_hdr, out_size_vld, out_last, out_data}, 0);
                    end else begin
                        logic [30:0] e;
                        e = expq.pop_front();
                        check(e[30] ? "R3/R4/R5/R6 header word" : "R2/R7 hit word",
                              {out_hdr, out_size_vld, out_last, out_data}, e);
                    end
                end
            end
        end
    end

    // Build expected words for the crossing held in vals.
    task automatic model(int pol, bit wide, int thr, int bunch);
        int hch[$];
        int lim, n, p;
        logic [3:0] sz;
        p = (pol == 0) ? 2 : pol;
        for (int c = 0; c < NCH; c++) if (vals[c] > thr) hch.push_back(c);
        lim = wide ? 16 : 8;
        if (p == 2) lim = lim - 1;
        n = (hch.size() < lim) ? hch.size() : lim;
        exp_drops += hch.size() - n;
        if (hch.size() > n) exp_ovf = 1'b1;
        if (p == 3 && n == 0) return;
        sz = (p == 2) ? 4'(n) : (n == 0 ? 4'd0 : 4'(n - 1));
        expq.push_back({1'b1, !(p == 1 && n == 0), n == 0, 12'(bunch), sensor_id, chip_id, sz});
        for (int k = 0; k < n; k++)
            expq.push_back({1'b0, 1'b0, k == n - 1, 15'd0, 7'(hch[k]), 6'(vals[hch[k]])});
    endtask

    // Clear vals and place n hits above thr from channel st with a stride.
    task automatic place(int n, int st, int stride, int thr);
        for (int c = 0; c < NCH; c++) vals[c] = 0;
        for (int k = 0; k < n; k++) vals[(st + k * stride) % NCH] = thr + 1 + (k % (63 - thr));
    endtask

    task automatic crossing(int pol, bit wide, int thr, int bunch);
        @(negedge clk);
        cfg_policy = 2'(pol);
        cfg_wide   = wide;
        threshold  = 6'(thr);
        bunch_id   = 12'(bunch);
        model(pol, wide, thr, bunch);
        for (int c = 0; c < NCH; c++) begin
            if (c > 0) @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_adc   = 6'(vals[c]);
            if (c == 1) begin
                bunch_id   = ~12'(bunch);
                cfg_policy = 2'(pol ^ 1);
                cfg_wide   = !wide;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (expq.size() != 0 || !in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 drop_count", drop_count, 64'(exp_drops));
        check("R8 ovf_flag", ovf_flag, 64'(exp_ovf));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset out_valid", out_valid, 0);
        check("reset in_ready R10", in_ready, 1);
        check("reset ovf_flag R8", ovf_flag, 0);
        check("reset drop_count R8", drop_count, 0);
        rst_n = 1'b1;
        place(0, 0, 1, 3);  crossing(2, 0, 3, 12'h101);   // R5 empty, size 0
        place(0, 0, 1, 3);  crossing(1, 0, 3, 12'h102);   // R4 empty, no size
        place(0, 0, 1, 3);  crossing(3, 1, 3, 12'h103);   // R6 empty, nothing
        place(0, 0, 1, 3);  vals[0] = 4; vals[10] = 3; vals[11] = 4; vals[127] = 63;
        crossing(1, 0, 3, 12'h204);                       // R1 threshold boundary
        rmode = 1;
        place(8, 5, 15, 3);  crossing(1, 0, 3, 12'h305);  // R7 exactly 8
        place(5, 2, 20, 0);  crossing(3, 0, 0, 12'h306);  // R6 thr 0
        place(15, 1, 8, 10); crossing(2, 1, 10, 12'h307); // R5 exactly 15
        check("R8 no drop yet", ovf_flag, 0);
        place(9, 3, 13, 3);  crossing(1, 0, 3, 12'h408);  // R7 9 hits, drop 1
        place(8, 0, 16, 3);  crossing(2, 0, 3, 12'h409);  // R5 keep 7, drop 1
        rmode = 0;
        place(20, 4, 6, 20); crossing(3, 1, 20, 12'hABC); // R7 keep 16, drop 4
        place(3, 7, 40, 3);  crossing(0, 0, 3, 12'hFFF);  // R5 mode 0 as policy 2
        place(2, 126, 1, 62); crossing(1, 1, 62, 12'h00A); // R2 top channels, R8 sticky
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule